// File: doc/BRIEF.md
# Legacy Disk I/O Trap Unit

This block watches host I/O cycles aimed at a disk controller that runs in its legacy register layout. There are two command blocks, at 1F0h–1F7h and 170h–177h, and two control ports, at 3F6h and 376h. When trapping is enabled for the drive that a cycle reaches, the block holds back the cycle's forward-enable so the controller never sees it. It then pulses a system-management interrupt (SMI) and sets a sticky status bit for that drive.

The block also watches a 16-byte bus-master register window at a programmable base. A trapped cycle into that window still reaches the controller, but it raises the SMI and sets a separate status bit. Each channel has a master and a slave drive. The block works out which one a cycle targets by snooping bit 4 of the writes to each channel's drive/head port.

Top module: `legacy_io_trap`

## Requirements
- R1: After reset `smi` is 0 and `trap_sts` is 0, both channels select their master drive, and `fwd_en` is 0 while `io_valid` is 0.
- R2: Only 1F0h–1F7h, 3F6h (primary channel), 170h–177h and 376h (secondary channel) count as legacy ranges. Their neighbours, such as 1EFh, 1F8h, 3F5h, 3F7h, 16Fh, 178h, 375h and 377h, never trap.
- R3: Legacy-range trapping needs both `legacy_mode` and `decode_en` high. Bus-master trapping needs `legacy_mode` high. Otherwise the cycle is forwarded with no SMI and no status change.
- R4: A trapped legacy cycle holds `fwd_en` at 0 in its own cycle. `smi` is 1 for exactly the following cycle, and in that cycle `trap_sts[dev]` is set.
- R5: The drive index is dev = 2*channel + slave: 0 primary master, 1 primary slave, 2 secondary master, 3 secondary slave. The trap for drive dev is enabled by `trap_en[dev]`.
- R6: For each channel, bit 4 of the last write to its drive/head port (1F6h primary, 176h secondary) selects the slave when set. The channels are independent. A write to that port is judged with the selection that held before the write.
- R7: The bus-master window is the 16 bytes whose address[15:4] equals `bm_base[15:4]`. Address bit 3 picks the channel (0 primary, 1 secondary). A trapped cycle in the window keeps `fwd_en` at 1, pulses `smi` in the next cycle and sets `trap_sts[4+dev]`. A legacy-range match takes priority over the window.
- R8: An untrapped cycle has `fwd_en` equal to 1 in its own cycle, gives no `smi` and leaves `trap_sts` unchanged.
- R9: With `sts_clr_valid` high, every bit that is 1 in `sts_clr_mask` clears at the next edge. A trap set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| io_valid | input | 1 | An I/O cycle is present this clock |
| io_write | input | 1 | 1 for a write, 0 for a read |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data (bit 4 is snooped for drive select) |
| legacy_mode | input | 1 | Controller is in legacy register layout |
| decode_en | input | 1 | Controller is decoding the legacy addresses |
| trap_en | input | 4 | Per-drive trap enables, index dev |
| bm_base | input | 16 | Base of the bus-master window (low 4 bits ignored) |
| sts_clr_valid | input | 1 | Apply a write-ones-to-clear of the status |
| sts_clr_mask | input | 8 | Status bits to clear |
| fwd_en | output | 1 | Pass the current cycle to the controller |
| smi | output | 1 | One-cycle SMI pulse per trapped cycle |
| trap_sts | output | 8 | [3:0] legacy-range trap per drive, [7:4] bus-master trap per drive |

## Verification
A stale drive-select bit shows one cycle later as an SMI and a status bit on the wrong drive. It can also show as a trap that goes missing because the enable of the other drive was consulted. A wrong range decode shows at once as `fwd_en` being low on a cycle that should pass, or high on one that should be held back. Status corruption persists until the next clear, so the bench clears after every cycle and compares the full status word one cycle after each access.

// File: rtl/legacy_io_trap.sv
module legacy_io_trap #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_valid,
  input  logic            io_write,
  input  logic [AW-1:0]   io_addr,
  input  logic [DW-1:0]   io_wdata,
  input  logic            legacy_mode,
  input  logic            decode_en,
  input  logic [NDEV-1:0] trap_en,
  input  logic [AW-1:0]   bm_base,
  input  logic            sts_clr_valid,
  input  logic [2*NDEV-1:0] sts_clr_mask,
  output logic            fwd_en,
  output logic            smi,
  output logic [2*NDEV-1:0] trap_sts
);
  localparam int SW = 2 * NDEV;
  localparam logic [AW-1:0] PRI_CMD = AW'(16'h01F0);
  localparam logic [AW-1:0] SEC_CMD = AW'(16'h0170);
  localparam logic [AW-1:0] PRI_CTL = AW'(16'h03F6);
  localparam logic [AW-1:0] SEC_CTL = AW'(16'h0376);
  localparam logic [AW-1:0] PRI_DRV = PRI_CMD + AW'(6);
  localparam logic [AW-1:0] SEC_DRV = SEC_CMD + AW'(6);

  logic [1:0] dsel;

  wire pri_cmd = io_addr[AW-1:3] == PRI_CMD[AW-1:3];
  wire sec_cmd = io_addr[AW-1:3] == SEC_CMD[AW-1:3];
  wire pri_hit = pri_cmd | (io_addr == PRI_CTL);
  wire sec_hit = sec_cmd | (io_addr == SEC_CTL);
  wire leg_hit = pri_hit | sec_hit;
  wire bm_hit  = !leg_hit && (io_addr[AW-1:4] == bm_base[AW-1:4]);

  wire       chan = leg_hit ? sec_hit : io_addr[3];
  wire [1:0] dev  = {chan, dsel[chan]};
  wire       en   = trap_en[dev];

  wire trap_leg = io_valid & legacy_mode & decode_en & leg_hit & en;
  wire trap_bm  = io_valid & legacy_mode & bm_hit & en;

  assign fwd_en = io_valid & ~trap_leg;

  logic [SW-1:0] set_vec;
  always_comb begin
    set_vec = '0;
    if (trap_leg) set_vec[dev] = 1'b1;
    if (trap_bm)  set_vec[NDEV + int'(dev)] = 1'b1;
  end

  wire [SW-1:0] clr_vec = sts_clr_valid ? sts_clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi      <= 1'b0;
      trap_sts <= '0;
      dsel     <= '0;
    end else begin
      smi      <= trap_leg | trap_bm;
      trap_sts <= (trap_sts & ~clr_vec) | set_vec;
      if (io_valid && io_write && io_addr == PRI_DRV) dsel[0] <= io_wdata[4];
      if (io_valid && io_write && io_addr == SEC_DRV) dsel[1] <= io_wdata[4];
    end
  end
endmodule

// File: rtl/legacy_io_trap_chk.sv
module legacy_io_trap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_valid,
  input logic       legacy_mode,
  input logic       sts_clr_valid,
  input logic       fwd_en,
  input logic       smi,
  input logic [7:0] trap_sts
);
  AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n) !io_valid |-> !fwd_en); // R1
  AST_HELD_GIVES_SMI: assert property (@(posedge clk) disable iff (!rst_n) (io_valid && !fwd_en) |=> smi); // R4
  AST_SMI_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n) !(io_valid && legacy_mode) |=> !smi); // R3
  AST_SMI_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n) smi |-> (trap_sts != 8'h00)); // R4
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !sts_clr_valid |=> (smi || $stable(trap_sts))); // R9
endmodule

bind legacy_io_trap legacy_io_trap_chk u_chk (.*);

// File: tb/test_legacy_io_trap.sv
module test_legacy_io_trap;
  logic clk = 0, rst_n = 0;
  logic io_valid = 0, io_write = 0, legacy_mode = 0, decode_en = 0, sts_clr_valid = 0;
  logic [15:0] io_addr = '0, bm_base = 16'hC000;
  logic [7:0] io_wdata = '0, sts_clr_mask = '0;
  logic [3:0] trap_en = '0;
  logic fwd_en, smi;
  logic [7:0] trap_sts;
  int checks = 0, fails = 0;
  logic [1:0] msel = 0;

  always #4 clk = ~clk;

  legacy_io_trap i_legacy_io_trap (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h addr=%h en=%h", req, act, exp, io_addr, trap_en);
    end
  endtask

  function automatic logic [9:0] model(logic [15:0] a, logic [3:0] en, logic lm, logic de);
    logic leg, sec, ch, bm, trap;
    logic [1:0] dv;
    logic [7:0] sts;
    leg = (a >= 16'h1F0 && a <= 16'h1F7) || a == 16'h3F6 || (a >= 16'h170 && a <= 16'h177) || a == 16'h376;
    sec = (a >= 16'h170 && a <= 16'h177) || a == 16'h376;
    bm  = !leg && (a / 16 == bm_base / 16);
    ch  = leg ? sec : ((a % 16) >= 8);
    dv  = {ch, msel[ch]};
    sts = 0;
    trap = 0;
    if (leg && lm && de && en[dv]) begin sts[dv] = 1; trap = 1; end
    if (bm && lm && en[dv]) begin sts[4+dv] = 1; trap = 1; end
    return {!(leg && lm && de && en[dv]), trap, sts};
  endfunction

  task automatic access(logic [15:0] a, logic wr, logic [7:0] d, string req);
    logic [9:0] e;
    e = model(a, trap_en, legacy_mode, decode_en);
    @(negedge clk);
    io_valid = 1; io_write = wr; io_addr = a; io_wdata = d;
    #1 chk(req, {7'd0, fwd_en}, {7'd0, e[9]});
    @(negedge clk);
    io_valid = 0;
    if (wr && a == 16'h1F6) msel[0] = d[4];
    if (wr && a == 16'h176) msel[1] = d[4];
    chk(req, {7'd0, smi}, {7'd0, e[8]});
    chk(req, trap_sts, e[7:0]);
    sts_clr_valid = 1; sts_clr_mask = 8'hFF;
    @(negedge clk);
    sts_clr_valid = 0; sts_clr_mask = 0;
  endtask

  task automatic set_sel(logic p, logic s);
    logic [3:0] sv;
    sv = trap_en; trap_en = 0;
    access(16'h1F6, 1, {3'b0, p, 4'b0}, "R6");
    access(16'h176, 1, {3'b0, s, 4'b0}, "R6");
    trap_en = sv;
  endtask

  logic [15:0] addrs [0:5] = '{16'h160, 16'h1E8, 16'h370, 16'h3F0, 16'hBFF8, 16'hC000};
  int lens [0:5] = '{32, 24, 16, 16, 8, 24};

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    #20 rst_n = 1;
    @(negedge clk);
    chk("R1", {6'd0, fwd_en, smi}, 8'd0);
    chk("R1", trap_sts, 8'd0);
    // R1 master selected after reset: primary master trap only
    legacy_mode = 1; decode_en = 1; trap_en = 4'b0001;
    access(16'h1F0, 0, 0, "R1");
    // R2 R4 R5 R7 R8 sweep
    for (int s = 0; s < 4; s++) begin
      set_sel(s[0], s[1]);
      for (int en = 0; en < 16; en++) begin
        trap_en = en[3:0];
        for (int r = 0; r < 6; r++)
          for (int k = 0; k < lens[r]; k++)
            access(addrs[r] + 16'(k), 0, 0, "R2_R4_R5_R7_R8");
      end
    end
    // R3 mode gating
    trap_en = 4'hF;
    for (int m = 0; m < 3; m++) begin
      legacy_mode = (m != 1); decode_en = (m != 2);
      for (int k = 0; k < 8; k++) access(16'h1F0 + 16'(k), 0, 0, "R3");
      access(16'h3F6, 0, 0, "R3");
      access(16'hC000, 0, 0, "R3");
      access(16'hC008, 0, 0, "R3");
    end
    legacy_mode = 1; decode_en = 1;
    // R6 write to drive/head judged with previous selection
    set_sel(0, 0);
    trap_en = 4'b0010;
    access(16'h1F6, 1, 8'h10, "R6");
    access(16'h1F6, 1, 8'h00, "R6");
    trap_en = 4'b1000;
    access(16'h176, 1, 8'h10, "R6");
    access(16'h177, 0, 0, "R6");
    // R9 set wins over clear, partial clear
    trap_en = 4'hF;
    @(negedge clk);
    io_valid = 1; io_addr = 16'h1F0; sts_clr_valid = 1; sts_clr_mask = 8'hFF;
    @(negedge clk);
    io_valid = 0; sts_clr_valid = 0;
    chk("R9", trap_sts, 8'h01);
    io_valid = 1; io_addr = 16'hC008;
    @(negedge clk);
    io_valid = 0;
    chk("R9", trap_sts, 8'h81);
    sts_clr_valid = 1; sts_clr_mask = 8'h80;
    @(negedge clk);
    sts_clr_valid = 0;
    chk("R9", trap_sts, 8'h01);
    repeat (2) @(negedge clk);
    chk("R9", trap_sts, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule